// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Port

This block is a memory-mapped SPI master that moves data one byte at a time. Software loads outgoing bytes into a 16-entry transmit queue through a data window, and it drains the bytes captured from the peripheral through the same window from a 16-entry receive queue. A control word sets the clock polarity and phase, selects one of three peripherals or none, sets the chip-select active levels, starts and stops the transfer, enables two interrupt causes and selects a read-only three-wire mode. A divider register sets the serial clock rate.

Each byte is shifted out MSB first and takes eight serial clock periods, followed by one idle period. This gives nine periods per byte when bytes run back to back. The serial clock frequency is the core clock divided by an even divider value. While the transfer-active bit is set, the engine keeps pulling bytes from the transmit queue. It stops when that queue is empty, and it stalls when the receive queue has no room. Software can run the block by polling the status flags or by taking the interrupt, which asks for service when the engine has finished or when the receive queue is filling up.

The register window uses byte offsets. Offset 0x0 is the control/status word, 0x4 is the data window and 0x8 is the divider. A read of the data window returns the head of the receive queue, and a read strobe pops it.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the control/status word reads 0x00040000, which means only the transmit-space flag is set. The divider reads 0, sclk is 0, all csOut are 1, irq is 0 and mosiOe is 1.
- R2: Bytes go out MSB first on mosi. Every byte sent captures exactly one byte from misoIn into the receive queue, in send order. This holds in all four modes, where control bit 2 is the phase and control bit 3 is the polarity. With phase 0 the block samples on the leading edge; with phase 1 it samples on the trailing edge.
- R3: Whenever no transfer is running, sclk rests at the polarity bit (bit 3). During a byte, each sclk level lasts divider/2 core clocks.
- R4: Bit 0 of a divider write is dropped, so the register always reads back even. A stored value of 0 gives a half period of 32768 core clocks, which is a division by 65536.
- R5: For bytes sent back to back, the first leading edges of consecutive bytes are exactly 9 × divider core clocks apart. This is eight data periods plus one idle period.
- R6: The done flag (bit 16) reads 1 when transfer-active (bit 7) is set, the transmit queue is empty and no byte is in flight. It reads 0 again once a byte is written. When the done-interrupt enable (bit 9) is set, irq follows this flag.
- R7: The status word reports the receive queue through three flags. Bit 17 is set when the queue is non-empty, bit 19 when it holds at least 12 bytes (three quarters) and bit 20 when it is full. Bit 18 reports that the transmit queue has space. A data write to a full transmit queue is dropped. With the receive interrupt enable (bit 10) set, irq follows bit 19.
- R8: Writing 1 to control bit 4 empties the transmit queue and writing 1 to bit 5 empties the receive queue. Both bits read back as 0.
- R9: While transfer-active is set, chip select number csSel (bits 1:0) is driven to its active level, and every other chip select is driven to the opposite level. When csSel is 3, no chip select is driven active. The active level of select i is 1 if bit 21+i or the global level bit 6 is set, and 0 otherwise.
- R10: When the read bit (bit 12) is set, mosiOe is 0 and the captured data comes from whatever level the shared line carries. When the read bit is clear, mosiOe is 1.
- R11: Clearing transfer-active in the middle of a byte aborts that byte. Within two cycles sclk returns to its rest level, all chip selects go inactive and no byte is captured.
- R12: The engine does not start a byte while the receive queue is full. It resumes once software pops a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Read strobe; pops the receive queue when busAddr is 0x4 |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 24 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for mosi |
| misoIn | input | 1 | Serial data in (shared line in three-wire mode) |
| csOut | output | 3 | Chip select pins |
| irq | output | 1 | Interrupt request |

## Verification
The in-module checks assume that software pushes only while the transmit-space flag is set and pops only while the receive-data flag is set. The control logic gates both strobes on those same conditions, so the queue checks catch any sequencing slip inside the block rather than software misuse. The bench stays within these assumptions, with one exception: it deliberately writes a seventeenth byte into a full queue. It does this to observe at the ports that the byte is dropped. It also never changes the polarity in the same write that clears transfer-active, which keeps the rest-level check meaningful.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int CS_COUNT = 3;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic rxPush;
  } strobe_t;
endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             din,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= din;
  end

  assign dout = mem[rdPtr];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !clr) |-> (count < CW'(DEPTH)))
    else $error("queue pushed while full");

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !clr) |-> (count != '0))
    else $error("queue popped while empty");
endmodule

// File: rtl/spi_ctl_dp.sv
module spi_ctl_dp
  import spi_ctl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [7:0]                  wrByte,
  input  logic                        lineIn,
  output logic [7:0]                  rdByte,
  output logic [$clog2(DEPTH+1)-1:0]  txCount,
  output logic [$clog2(DEPTH+1)-1:0]  rxCount,
  output logic                        txBit
);
  logic [7:0] txHead;
  logic [7:0] txShift, rxShift;

  spi_ctl_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .clr(stb.txClr), .push(stb.txPush), .pop(stb.load),
    .din(wrByte), .dout(txHead), .count(txCount));

  spi_ctl_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .clr(stb.rxClr), .push(stb.rxPush), .pop(stb.rxPop),
    .din(rxShift), .dout(rdByte), .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.load)          txShift <= txHead;
      else if (stb.shiftOut) txShift <= {txShift[6:0], 1'b0};
      if (stb.sampleIn)      rxShift <= {rxShift[6:0], lineIn};
    end
  end

  assign txBit = txShift[7];
endmodule

// File: rtl/spi_ctl_ctrl.sv
module spi_ctl_ctrl
  import spi_ctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWe,
  input  logic                        busRe,
  input  logic [3:0]                  busAddr,
  input  logic [23:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [7:0]                  rdByte,
  input  logic [$clog2(DEPTH+1)-1:0]  txCount,
  input  logic [$clog2(DEPTH+1)-1:0]  rxCount,
  output strobe_t                     stb,
  output logic                        sclk,
  output logic                        mosiOe,
  output logic [CS_COUNT-1:0]         csOut,
  output logic                        irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] NEED_LVL = CW'((DEPTH * 3) / 4);
  localparam logic [CW-1:0] MORE_LIM = CW'(DEPTH - 1);
  localparam logic [DIV_W-1:0] SLOW_HALF = DIV_W'(1) << (DIV_W - 1);
  localparam logic [4:0] LAST_HALF = 5'd17;

  // control fields
  logic [1:0]          csSel;
  logic                cpha, cpol, gpol, ta, intd, intr, ren;
  logic [CS_COUNT-1:0] perPol;
  logic [DIV_W-1:0]    divReg;

  // engine state
  logic                busy, sclkAct;
  logic [DIV_W-2:0]    halfCnt;
  logic [4:0]          halfIdx;

  logic wrCtl, wrData, wrDiv, rdData;
  logic txEmpty, txFull, rxEmpty, rxFull, rxNeed, done;
  logic [DIV_W-1:0] halfPer;
  logic tick, leadEdge, trailEdge, byteEnd, startNow, moreNow;

  assign wrCtl  = busWe && (busAddr[3:2] == 2'd0);
  assign wrData = busWe && (busAddr[3:2] == 2'd1);
  assign wrDiv  = busWe && (busAddr[3:2] == 2'd2);
  assign rdData = busRe && (busAddr[3:2] == 2'd1);

  assign txEmpty = (txCount == '0);
  assign txFull  = (txCount == FULL_LVL);
  assign rxEmpty = (rxCount == '0);
  assign rxFull  = (rxCount == FULL_LVL);
  assign rxNeed  = (rxCount >= NEED_LVL);
  assign done    = ta && txEmpty && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSel  <= '0; cpha <= 1'b0; cpol <= 1'b0; gpol <= 1'b0;
      ta     <= 1'b0; intd <= 1'b0; intr <= 1'b0; ren <= 1'b0;
      perPol <= '0;
      divReg <= '0;
    end else begin
      if (wrCtl) begin
        csSel  <= busWdata[1:0];
        cpha   <= busWdata[2];
        cpol   <= busWdata[3];
        gpol   <= busWdata[6];
        ta     <= busWdata[7];
        intd   <= busWdata[9];
        intr   <= busWdata[10];
        ren    <= busWdata[12];
        perPol <= busWdata[21 +: CS_COUNT];
      end
      if (wrDiv) divReg <= {busWdata[DIV_W-1:1], 1'b0};
    end
  end

  // half-period timing
  assign halfPer   = (divReg == '0) ? SLOW_HALF : {1'b0, divReg[DIV_W-1:1]};
  assign tick      = busy && ta && ({1'b0, halfCnt} == (halfPer - 1'b1));
  assign leadEdge  = tick && (halfIdx < 5'd16) && !halfIdx[0];
  assign trailEdge = tick && (halfIdx < 5'd16) &&  halfIdx[0];
  assign byteEnd   = tick && (halfIdx == LAST_HALF);
  assign startNow  = !busy && ta && !txEmpty && !rxFull;
  assign moreNow   = ta && !txEmpty && (rxCount < MORE_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclkAct <= 1'b0;
      halfCnt <= '0;
      halfIdx <= '0;
    end else if (!ta) begin
      busy    <= 1'b0;
      sclkAct <= 1'b0;
      halfCnt <= '0;
      halfIdx <= '0;
    end else if (startNow) begin
      busy    <= 1'b1;
      sclkAct <= 1'b0;
      halfCnt <= '0;
      halfIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        halfCnt <= '0;
        if (halfIdx == LAST_HALF) begin
          halfIdx <= '0;
          busy    <= moreNow;
        end else begin
          halfIdx <= halfIdx + 1'b1;
        end
        if (leadEdge)       sclkAct <= 1'b1;
        else if (trailEdge) sclkAct <= 1'b0;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // strobes toward the datapath
  always_comb begin
    stb          = '0;
    stb.txPush   = wrData && !txFull;
    stb.rxPop    = rdData && !rxEmpty;
    stb.txClr    = wrCtl && busWdata[4];
    stb.rxClr    = wrCtl && busWdata[5];
    stb.load     = startNow || (byteEnd && moreNow);
    stb.sampleIn = cpha ? trailEdge : leadEdge;
    stb.shiftOut = cpha ? (leadEdge && (halfIdx != '0)) : trailEdge;
    stb.rxPush   = byteEnd;
  end

  // pins
  assign sclk   = cpol ^ sclkAct;
  assign mosiOe = !ren;
  assign irq    = (intd && done) || (intr && rxNeed);

  logic [CS_COUNT-1:0] csLvl, csSeen;
  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign csLvl[i]  = perPol[i] | gpol;
    assign csOut[i]  = (ta && (csSel != 2'b11) && (csSel == 2'(i))) ? csLvl[i] : ~csLvl[i];
    assign csSeen[i] = ~(csOut[i] ^ csLvl[i]);
  end

  // register read
  always_comb begin
    case (busAddr[3:2])
      2'd0: busRdata = {8'd0, perPol, rxFull, rxNeed, !txFull, !rxEmpty, done,
                        3'd0, ren, 1'b0, intr, intd, 1'b0, ta, gpol, 2'b00,
                        cpol, cpha, csSel};
      2'd1: busRdata = {24'd0, rdByte};
      2'd2: busRdata = {{(32-DIV_W){1'b0}}, divReg};
      default: busRdata = '0;
    endcase
  end

  p_single_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csSeen))
    else $error("more than one chip select active");

  p_rest_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ta && !$past(ta)) |-> (sclk == cpol))
    else $error("sclk off its rest level while stopped");
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [3:0]          busAddr,
  input  logic [23:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                sclk,
  output logic                mosi,
  output logic                mosiOe,
  input  logic                misoIn,
  output logic [CS_COUNT-1:0] csOut,
  output logic                irq
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  strobe_t        stb;
  logic [7:0]     rdByte;
  logic [CW-1:0]  txCount, rxCount;

  spi_ctl_ctrl #(.DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rdByte(rdByte),
    .txCount(txCount), .rxCount(rxCount), .stb(stb), .sclk(sclk),
    .mosiOe(mosiOe), .csOut(csOut), .irq(irq));

  spi_ctl_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(busWdata[7:0]), .lineIn(misoIn),
    .rdByte(rdByte), .txCount(txCount), .rxCount(rxCount), .txBit(mosi));
endmodule

// File: tb/sim_spi_ctl_top.sv
module sim_spi_ctl_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [23:0] K_CPHA  = 24'h000004;
  localparam logic [23:0] K_CPOL  = 24'h000008;
  localparam logic [23:0] K_CLRTX = 24'h000010;
  localparam logic [23:0] K_CLRRX = 24'h000020;
  localparam logic [23:0] K_GLVL  = 24'h000040;
  localparam logic [23:0] K_RUN   = 24'h000080;
  localparam logic [23:0] K_IDONE = 24'h000200;
  localparam logic [23:0] K_IRX   = 24'h000400;
  localparam logic [23:0] K_READ  = 24'h001000;
  localparam logic [23:0] K_LVL1  = 24'h400000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [23:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sclk, mosi, mosiOe, misoIn, irq;
  logic [2:0] csOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // shared line: loops back mosi, pulled high when nobody drives it
  assign misoIn = mosiOe ? mosi : 1'b1;

  spi_ctl_top u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .mosiOe(mosiOe), .misoIn(misoIn), .csOut(csOut), .irq(irq));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic popRx(output logic [7:0] b);
    @(negedge clk);
    busAddr = 4'h4; busRe = 1'b1;
    #1 b = busRdata[7:0];
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // driver: pushes a byte and the byte it expects back
  task automatic sendByte(input logic [7:0] b, input logic [7:0] e);
    writeReg(4'h4, {16'd0, b});
    expQ.push_back(e);
  endtask

  task automatic waitDone(input string tag);
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      busAddr = 4'h0;
      #1 seen = busRdata[16];
    end
    if (!seen) check({tag, " done timeout"}, 32'd0, 32'd1);
  endtask

  // monitor: pops received bytes and compares them with the queue
  task automatic drainCheck(input string tag);
    logic [31:0] st;
    logic [7:0] b;
    waitDone(tag);
    readReg(4'h0, st);
    while (st[17]) begin
      popRx(b);
      if (expQ.size() == 0) check({tag, " unexpected byte"}, {24'd0, b}, 32'hFFFF_FFFF);
      else check(tag, {24'd0, b}, {24'd0, expQ.pop_front()});
      readReg(4'h0, st);
    end
    check({tag, " leftover"}, expQ.size(), 0);
  endtask

  task automatic measureEdges(input int rises, output int r1, output int f1, output int r9);
    int t = 0, nr = 0;
    logic prev = sclk;
    r1 = -1; f1 = -1; r9 = -1;
    while (t < 100000 && (nr < rises || f1 < 0)) begin
      @(negedge clk);
      t++;
      if (sclk && !prev) begin
        nr++;
        if (nr == 1) r1 = t;
        if (nr == 9) r9 = t;
      end
      if (!sclk && prev && f1 < 0) f1 = t;
      prev = sclk;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [7:0] b;
    int r1, f1, r9;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(4'h0, st);  check("R1 status", st, 32'h0004_0000);
    readReg(4'h8, st);  check("R1 divider", st, 32'd0);
    check("R1 pins", {28'd0, sclk, csOut}, {28'd0, 1'b0, 3'b111});
    check("R1 irq/oe", {30'd0, irq, mosiOe}, 32'd1);

    // R2/R3 four modes with loopback
    writeReg(4'h8, 24'd4);
    for (int m = 0; m < 4; m++) begin
      logic [23:0] md;
      md = (m[0] ? K_CPHA : 24'd0) | (m[1] ? K_CPOL : 24'd0);
      writeReg(4'h0, md);
      @(negedge clk);
      check("R3 rest level", {31'd0, sclk}, {31'd0, m[1]});
      sendByte(8'hA5, 8'hA5);
      sendByte(8'h3C, 8'h3C);
      sendByte(8'h81, 8'h81);
      writeReg(4'h0, md | K_RUN);
      drainCheck("R2 mode loopback");
      writeReg(4'h0, md);
    end

    // R3/R5 timing at divider 4
    writeReg(4'h0, 24'd0);
    sendByte(8'h55, 8'h55);
    sendByte(8'hF0, 8'hF0);
    writeReg(4'h0, K_RUN);
    measureEdges(9, r1, f1, r9);
    check("R3 half period", f1 - r1, 2);
    check("R5 byte spacing", r9 - r1, 36);
    drainCheck("R5 data");
    writeReg(4'h0, 24'd0);

    // R4 divider handling
    writeReg(4'h8, 24'd7);
    readReg(4'h8, st);  check("R4 odd divider", st, 32'd6);
    writeReg(4'h8, 24'd0);
    readReg(4'h8, st);  check("R4 zero divider", st, 32'd0);
    writeReg(4'h4, 24'h0000C3);
    writeReg(4'h0, K_RUN);
    measureEdges(1, r1, f1, r9);
    check("R4 slow half period", f1 - r1, 32768);
    // R11 abort while sclk is high
    for (int i = 0; i < 40000 && !sclk; i++) @(negedge clk);
    check("R11 sclk high before abort", {31'd0, sclk}, 32'd1);
    writeReg(4'h0, 24'd0);
    @(negedge clk);
    check("R11 pins after abort", {28'd0, sclk, csOut}, {28'd0, 1'b0, 3'b111});
    readReg(4'h0, st);  check("R11 no byte captured", {31'd0, st[17]}, 32'd0);

    // R6 done and its interrupt
    writeReg(4'h8, 24'd4);
    writeReg(4'h0, K_RUN | K_IDONE);
    readReg(4'h0, st);
    check("R6 done on empty start", {31'd0, st[16]}, 32'd1);
    check("R6 irq on done", {31'd0, irq}, 32'd1);
    sendByte(8'h12, 8'h12);
    readReg(4'h0, st);
    check("R6 done drops on write", {31'd0, st[16]}, 32'd0);
    check("R6 irq drops", {31'd0, irq}, 32'd0);
    waitDone("R6");
    check("R6 irq after byte", {31'd0, irq}, 32'd1);
    drainCheck("R6 data");
    writeReg(4'h0, 24'd0);
    check("R6 irq off when stopped", {31'd0, irq}, 32'd0);

    // R7/R12 queue flags, overflow drop and stall
    writeReg(4'h8, 24'd2);
    for (int i = 0; i < 16; i++) sendByte(8'(i * 7 + 1), 8'(i * 7 + 1));
    readReg(4'h0, st);  check("R7 tx full flag", {31'd0, st[18]}, 32'd0);
    writeReg(4'h4, 24'h0000EE);   // dropped
    writeReg(4'h0, K_RUN | K_IRX);
    waitDone("R7");
    readReg(4'h0, st);
    check("R7 rx flags when full", {29'd0, st[20:19], st[17]}, 32'h7);
    check("R7 irq on rx need", {31'd0, irq}, 32'd1);
    sendByte(8'h99, 8'h99);
    repeat (60) @(negedge clk);
    readReg(4'h0, st);
    check("R12 stalled while full", {30'd0, st[20], st[16]}, 32'h2);
    popRx(b);
    check("R12 first byte", {24'd0, b}, {24'd0, expQ.pop_front()});
    waitDone("R12");
    readReg(4'h0, st);  check("R12 resumed to full", {31'd0, st[20]}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      popRx(b);
      check("R7 pop", {24'd0, b}, {24'd0, expQ.pop_front()});
    end
    readReg(4'h0, st);  check("R7 need at 12", {31'd0, st[19]}, 32'd1);
    popRx(b);
    check("R7 pop", {24'd0, b}, {24'd0, expQ.pop_front()});
    readReg(4'h0, st);  check("R7 need clears at 11", {31'd0, st[19]}, 32'd0);
    check("R7 irq clears", {31'd0, irq}, 32'd0);
    drainCheck("R7 dropped write absent");
    writeReg(4'h0, 24'd0);

    // R8 clears
    writeReg(4'h4, 24'h11); writeReg(4'h4, 24'h22); writeReg(4'h4, 24'h33);
    writeReg(4'h0, K_CLRTX);
    readReg(4'h0, st);  check("R8 clear bits read 0", {30'd0, st[5:4]}, 32'd0);
    writeReg(4'h0, K_RUN);
    readReg(4'h0, st);
    check("R8 tx emptied", {30'd0, st[17:16]}, 32'h1);
    writeReg(4'h4, 24'h44); writeReg(4'h4, 24'h55);
    waitDone("R8");
    readReg(4'h0, st);  check("R8 rx has data", {31'd0, st[17]}, 32'd1);
    writeReg(4'h0, K_RUN | K_CLRRX);
    readReg(4'h0, st);  check("R8 rx emptied", {31'd0, st[17]}, 32'd0);
    writeReg(4'h0, 24'd0);

    // R9 chip selects
    writeReg(4'h0, K_RUN | 24'd1);
    check("R9 select 1 active low", {29'd0, csOut}, 32'b101);
    writeReg(4'h0, K_RUN | K_LVL1 | 24'd0);
    check("R9 per-select level", {29'd0, csOut}, 32'b100);
    writeReg(4'h0, K_RUN | 24'd3);
    check("R9 code 3 selects none", {29'd0, csOut}, 32'b111);
    writeReg(4'h0, K_RUN | K_GLVL | 24'd2);
    check("R9 global level", {29'd0, csOut}, 32'b100);
    writeReg(4'h0, 24'd0);
    check("R9 idle", {29'd0, csOut}, 32'b111);

    // R10 three-wire read
    writeReg(4'h0, K_READ);
    check("R10 driver off", {31'd0, mosiOe}, 32'd0);
    sendByte(8'h5A, 8'hFF);
    writeReg(4'h0, K_READ | K_RUN);
    drainCheck("R10 line sampled");
    writeReg(4'h0, 24'd0);
    check("R10 driver on", {31'd0, mosiOe}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule